// File: doc/BRIEF.md
# Precision Time-of-Day Clock Generator

This block keeps a time-of-day value split into a seconds count and a nanoseconds count, as used for precision time stamping. On each clock cycle the nanoseconds count can advance by a programmable increment. In coarse mode this happens on every cycle. In fine mode it happens only when a 32-bit phase accumulator overflows. The accumulator adds an active addend each cycle, so software trims the clock rate by choosing that addend.

Software reaches the block through a small word-addressed register port. It can stage a new addend and commit it. It can set the time to an absolute value, or shift the time forwards or backwards by a signed offset. Each of these changes happens in one cycle through a command bit that clears itself. A comparator watches the clock against a programmed target time and raises a maskable interrupt when the clock reaches it.

Top module: `ptp_time_gen`

Register words (by `addr`):

| Word | Name | Access | Content |
|------|------|--------|---------|
| 0 | CTRL | read/write | control and command bits, listed below |
| 1 | INCR | read/write | sub-second increment in nanoseconds |
| 2 | ADDEND stage | read/write | staged addend |
| 3 | ADDEND active | read-only | addend in use |
| 4 | offset seconds | read/write | seconds value for set-time or adjust |
| 5 | offset nanoseconds | read/write | nanoseconds value for set-time or adjust; bit 31 is the sign |
| 6 | target seconds | read/write | target time, seconds |
| 7 | target nanoseconds | read/write | target time, nanoseconds |
| 8 | now seconds | read-only | current time, seconds |
| 9 | now nanoseconds | read-only | current time, nanoseconds |

CTRL bits:

| Bit | Meaning |
|-----|---------|
| 0 | fine mode |
| 1 | set-time command |
| 2 | adjust command |
| 3 | addend-load command |
| 4 | trigger arm |
| 5 | interrupt mask |
| 6 | trigger status |

Software must keep every nanoseconds value it writes below 1,000,000,000. Each write to CTRL rewrites bits 0, 4 and 5 from the written data.

## Requirements
- R1: After reset, the time is 0 s and 0 ns, CTRL reads 0, the active addend (word 3) reads 0 and `irq` is low.
- R2: With CTRL bit 0 clear (coarse mode), the nanoseconds count grows by the INCR value (word 1) on every clock cycle.
- R3: The nanoseconds count never reaches 1,000,000,000. When an increment would reach or pass that value, 1,000,000,000 is subtracted and the seconds count grows by one in the same cycle.
- R4: With CTRL bit 0 set (fine mode), the active addend is added each cycle into a 32-bit accumulator, and INCR is applied only on cycles whose sum carries out. An addend of 0x8000_0000 therefore applies INCR on every second cycle, and an addend of 0 stops the clock.
- R5: A write to word 2 leaves the active addend unchanged. Writing CTRL with bit 3 set makes bit 3 read 1 for one cycle; after that, word 3 holds the staged value and bit 3 reads 0.
- R6: Writing CTRL with bit 1 set makes bit 1 read 1 for one cycle. At the next edge the time becomes word 4 and the low 30 bits of word 5, and no increment is applied on that edge.
- R7: Writing CTRL with bit 2 set while bit 31 of word 5 is 0 adds word 4 and the low bits of word 5 to the time at the next edge. A nanoseconds carry past one second adds one to the seconds. No increment is applied on that edge.
- R8: When bit 31 of word 5 is 1, the adjust command subtracts the offset instead. A nanoseconds borrow adds 1,000,000,000 to the nanoseconds and takes one from the seconds.
- R9: A write that sets CTRL bit 1 or bit 2 is ignored while either of those bits reads 1. If one write sets both, only the set-time command runs.
- R10: While CTRL bit 4 is set and the time is at or after the target (words 6 and 7), the next edge sets status bit 6 and clears bit 4. The status bit is set one edge after the time first reaches the target.
- R11: `irq` equals status bit 6 AND NOT mask bit 5. Writing CTRL with bit 6 set clears the status bit.
- R12: If a target hit and a status clear (a CTRL write with bit 6 set) fall on the same edge, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 4 | register word select |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for `addr`, combinational |
| time_sec | output | 32 | current seconds count |
| time_ns | output | 30 | current nanoseconds count |
| irq | output | 1 | target-time interrupt |

## Verification
Two of this block's functions can fall on the same edge: a target hit setting the status bit, and software clearing that same bit. The bench provokes this by arming the comparator with a target that is already in the past, then writing the clear on the very next cycle, so both act on one edge. It then judges that the status bit and `irq` stay high. A second overlap is provoked by issuing an adjust command on the edge where a set-time command is still executing. The bench judges that the time holds only the set value and that the adjust offset never appears.

// File: rtl/ptp_time_gen.sv
module ptp_time_gen #(
  parameter int     SEC_W   = 32,
  parameter int     NS_W    = 30,
  parameter int     INC_W   = 8,
  parameter int     ACC_W   = 32,
  parameter longint NS_ROLL = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic [SEC_W-1:0] time_sec,
  output logic [NS_W-1:0]  time_ns,
  output logic             irq
);
  localparam logic [NS_W:0] ROLL = (NS_W+1)'(NS_ROLL);

  logic             fine_en, set_busy, adj_busy, load_busy, trig_arm, irq_mask, trig_hit;
  logic [INC_W-1:0] incr;
  logic [ACC_W-1:0] add_stage, add_act, acc;
  logic [SEC_W-1:0] sec, upd_sec, tgt_sec;
  logic [NS_W-1:0]  ns, tgt_ns;
  logic [31:0]      upd_ns_raw;

  // rate accumulator
  logic [ACC_W:0] acc_sum;
  logic           tick;
  assign acc_sum = {1'b0, acc} + {1'b0, add_act};
  assign tick    = fine_en ? acc_sum[ACC_W] : 1'b1;

  // free-running advance
  logic [NS_W:0]    ns_inc;
  logic             ns_roll;
  logic [NS_W-1:0]  tick_ns;
  logic [SEC_W-1:0] tick_sec;
  assign ns_inc   = {1'b0, ns} + (NS_W+1)'(incr);
  assign ns_roll  = ns_inc >= ROLL;
  assign tick_ns  = ns_roll ? NS_W'(ns_inc - ROLL) : ns_inc[NS_W-1:0];
  assign tick_sec = sec + SEC_W'(ns_roll);

  // signed offset adjust
  logic [NS_W-1:0]  off_ns;
  logic             off_neg;
  logic [NS_W:0]    ns_sum, ns_dif;
  logic             sum_carry, dif_borrow;
  logic [NS_W-1:0]  adj_ns;
  logic [SEC_W-1:0] adj_sec;
  assign off_ns     = upd_ns_raw[NS_W-1:0];
  assign off_neg    = upd_ns_raw[31];
  assign ns_sum     = {1'b0, ns} + {1'b0, off_ns};
  assign ns_dif     = {1'b0, ns} - {1'b0, off_ns};
  assign sum_carry  = ns_sum >= ROLL;
  assign dif_borrow = ns_dif[NS_W];

  always_comb begin
    if (off_neg) begin
      adj_ns  = dif_borrow ? NS_W'(ns_dif + ROLL) : ns_dif[NS_W-1:0];
      adj_sec = sec - upd_sec - SEC_W'(dif_borrow);
    end else begin
      adj_ns  = sum_carry ? NS_W'(ns_sum - ROLL) : ns_sum[NS_W-1:0];
      adj_sec = sec + upd_sec + SEC_W'(sum_carry);
    end
  end

  // target comparator
  logic hit;
  assign hit = trig_arm && ((sec > tgt_sec) || ((sec == tgt_sec) && (ns >= tgt_ns)));

  logic cmd_free;
  assign cmd_free = !set_busy && !adj_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fine_en <= 1'b0; set_busy <= 1'b0; adj_busy <= 1'b0; load_busy <= 1'b0;
      trig_arm <= 1'b0; irq_mask <= 1'b0; trig_hit <= 1'b0;
      incr <= '0; add_stage <= '0; add_act <= '0; acc <= '0;
      sec <= '0; ns <= '0; upd_sec <= '0; upd_ns_raw <= '0;
      tgt_sec <= '0; tgt_ns <= '0;
    end else begin
      acc <= acc_sum[ACC_W-1:0];
      if (set_busy) begin
        sec      <= upd_sec;
        ns       <= off_ns;
        set_busy <= 1'b0;
      end else if (adj_busy) begin
        sec      <= adj_sec;
        ns       <= adj_ns;
        adj_busy <= 1'b0;
      end else if (tick) begin
        sec <= tick_sec;
        ns  <= tick_ns;
      end
      if (load_busy) begin
        add_act   <= add_stage;
        load_busy <= 1'b0;
      end
      if (hit) begin
        trig_hit <= 1'b1;
        trig_arm <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          4'd0: begin
            fine_en  <= wdata[0];
            trig_arm <= wdata[4];
            irq_mask <= wdata[5];
            if (wdata[3]) load_busy <= 1'b1;
            if (cmd_free && wdata[1])      set_busy <= 1'b1;
            else if (cmd_free && wdata[2]) adj_busy <= 1'b1;
            if (wdata[6] && !hit) trig_hit <= 1'b0;
          end
          4'd1: incr       <= wdata[INC_W-1:0];
          4'd2: add_stage  <= wdata[ACC_W-1:0];
          4'd4: upd_sec    <= wdata[SEC_W-1:0];
          4'd5: upd_ns_raw <= wdata;
          4'd6: tgt_sec    <= wdata[SEC_W-1:0];
          4'd7: tgt_ns     <= wdata[NS_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {25'b0, trig_hit, irq_mask, trig_arm, load_busy, adj_busy, set_busy, fine_en};
      4'd1:    rdata = 32'(incr);
      4'd2:    rdata = 32'(add_stage);
      4'd3:    rdata = 32'(add_act);
      4'd4:    rdata = 32'(upd_sec);
      4'd5:    rdata = upd_ns_raw;
      4'd6:    rdata = 32'(tgt_sec);
      4'd7:    rdata = 32'(tgt_ns);
      4'd8:    rdata = 32'(sec);
      4'd9:    rdata = 32'(ns);
      default: rdata = '0;
    endcase
  end

  assign time_sec = sec;
  assign time_ns  = ns;
  assign irq      = trig_hit && !irq_mask;

  a_r3_ns_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ns} < ROLL);

  a_r6_set_commit: assert property (@(posedge clk) disable iff (!rst_n)
    set_busy |=> (sec == $past(upd_sec)) && (ns == $past(upd_ns_raw[NS_W-1:0])));

  a_r9_one_command: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_busy && adj_busy));

  a_r5_addend_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_busy |=> (add_act == $past(add_stage)) && !load_busy);

  a_r12_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> trig_hit);
endmodule

// File: tb/ptp_time_gen_bench.sv
module ptp_time_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  localparam int unsigned V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
  localparam int unsigned V_ASEC [NV] = '{5, 7, 7, 0, 100, 42, 10, 10, 10, 10, 10};
  localparam int unsigned V_ANS  [NV] = '{100, 999999990, 999999950, 0, 999999999, 123456, 500, 500, 500, 500, 500};
  localparam int unsigned V_INC  [NV] = '{20, 20, 50, 10, 1, 7, 0, 0, 0, 0, 0};
  localparam int unsigned V_BSEC [NV] = '{0, 0, 0, 0, 0, 0, 1, 2, 0, 3, 0};
  localparam int unsigned V_BNS  [NV] = '{0, 0, 0, 0, 0, 0, 999999600, 300,
                                          32'h8000_0000 | 600, 32'h8000_0000 | 100, 32'h8000_0000 | 500};
  localparam int unsigned V_CYC  [NV] = '{10, 1, 1, 0, 3, 100, 0, 0, 0, 0, 0};
  localparam int unsigned V_ESEC [NV] = '{5, 8, 8, 0, 101, 42, 12, 12, 9, 7, 10};
  localparam int unsigned V_ENS  [NV] = '{300, 10, 0, 0, 2, 124156, 100, 800, 999999900, 400, 0};

  logic        clk = 1'b0;
  logic        rst_n, wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [31:0] time_sec;
  logic [29:0] time_ns;
  logic        irq;

  int checks = 0;
  int failures = 0;

  ptp_time_gen u_ptp_time_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .time_sec(time_sec), .time_ns(time_ns), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [29:0] t0;
    bit seen;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 sec", time_sec, 0);
    check("R1 ns", time_ns, 0);
    check("R1 irq", irq, 0);
    rd(4'd0, r); check("R1 ctrl", r, 0);
    rd(4'd3, r); check("R1 addend", r, 0);
    idle(1);

    // table: set-time then run (mode 0) or set-time then adjust (mode 1)
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (V_MODE[i] == 1) tag = V_BNS[i][31] ? "R8" : "R7";
      else if (V_CYC[i] == 0) tag = "R6";
      else tag = (V_ESEC[i] != V_ASEC[i]) ? "R3" : "R2";
      wr(4'd1, V_INC[i]);
      wr(4'd4, V_ASEC[i]);
      wr(4'd5, V_ANS[i]);
      wr(4'd0, 32'h2);
      rd(4'd0, r); check("R6 busy", r[1], 1);
      idle(1);
      if (V_MODE[i] == 0) begin
        check("R6 set sec", time_sec, V_ASEC[i]);
        check("R6 set ns", time_ns, V_ANS[i]);
        idle(V_CYC[i]);
      end else begin
        wr(4'd4, V_BSEC[i]);
        wr(4'd5, V_BNS[i]);
        wr(4'd0, 32'h4);
        idle(1);
      end
      check({tag, " sec"}, time_sec, V_ESEC[i]);
      check({tag, " ns"}, time_ns, V_ENS[i]);
    end

    // R9: adjust issued while set-time still running is dropped
    wr(4'd1, 0);
    wr(4'd4, 10);
    wr(4'd5, 500);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h4);
    idle(2);
    check("R9 sec", time_sec, 10);
    check("R9 ns", time_ns, 500);
    rd(4'd0, r); check("R9 bits idle", r[2:1], 0);
    // R9: both bits in one write, set-time wins
    wr(4'd4, 3);
    wr(4'd5, 0);
    wr(4'd0, 32'h6);
    idle(1);
    check("R9 both sec", time_sec, 3);
    check("R9 both ns", time_ns, 0);

    // R5 addend staging and load
    wr(4'd2, 32'h8000_0000);
    rd(4'd3, r); check("R5 stage no effect", r, 0);
    wr(4'd0, 32'h9);
    rd(4'd0, r); check("R5 load busy", r[3], 1);
    idle(1);
    rd(4'd0, r); check("R5 load clear", r[3], 0);
    rd(4'd3, r); check("R5 active", r, 32'h8000_0000);

    // R4 fine mode: half-rate ticks
    wr(4'd1, 10);
    wr(4'd4, 1);
    wr(4'd5, 0);
    wr(4'd0, 32'h3);
    idle(1);
    check("R4 start", time_ns, 0);
    idle(20);
    check("R4 half rate ns", time_ns, 100);
    check("R4 half rate sec", time_sec, 1);
    // R4 addend 0 freezes the clock
    wr(4'd2, 0);
    wr(4'd0, 32'h9);
    idle(2);
    t0 = time_ns;
    idle(10);
    check("R4 frozen", time_ns, t0);
    // R2 back to coarse
    wr(4'd0, 32'h0);
    t0 = time_ns;
    idle(5);
    check("R2 coarse", time_ns, t0 + 50);

    // R10 trigger
    wr(4'd1, 100);
    wr(4'd4, 20);
    wr(4'd5, 0);
    wr(4'd0, 32'h2);
    wr(4'd6, 20);
    wr(4'd7, 1000);
    wr(4'd0, 32'h10);
    check("R10 no early irq", irq, 0);
    seen = 0;
    for (int k = 0; k < 50; k++) begin
      if (irq) begin seen = 1; break; end
      @(negedge clk);
    end
    check("R10 fired", seen, 1);
    check("R10 fire time", time_ns, 1100);
    rd(4'd0, r);
    check("R10 arm cleared", r[4], 0);
    check("R10 status", r[6], 1);

    // R11 mask and clear
    wr(4'd0, 32'h20);
    check("R11 masked", irq, 0);
    rd(4'd0, r); check("R11 status kept", r[6], 1);
    wr(4'd0, 32'h0);
    check("R11 unmasked", irq, 1);
    wr(4'd0, 32'h40);
    check("R11 cleared irq", irq, 0);
    rd(4'd0, r); check("R11 cleared status", r[6], 0);

    // R12 hit and clear on the same edge
    wr(4'd0, 32'h10);
    wr(4'd0, 32'h40);
    rd(4'd0, r); check("R12 status kept", r[6], 1);
    check("R12 irq", irq, 1);
    wr(4'd0, 32'h40);
    check("R12 later clear", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule